// File: doc/BRIEF.md
# Fieldbus Transmit Encoder with Jabber Guard

This block is the digital transmit front end of a low-speed fieldbus line driver. A communication controller supplies a transmit-enable and a transmit-data line. The block turns them into three switch-control outputs for an analog three-level modulator:

- a lower drive switch;
- an upper drive switch;
- an idle-level adjust switch. This one is closed only while the line rests at its static level, so the resting level can be shifted for low-power signalling.

A watchdog counts how long transmit-enable stays asserted. When enable stays high beyond a configured number of clock cycles, the watchdog stops the transmission. It returns the switches to the static pattern and holds a fault flag until enable is released.

All three switch outputs come from registers. They change together on a clock edge, with one cycle of latency from the sampled inputs. The data rate is low (tens of kbit/s) compared with the system clock, so this latency does not matter for bit timing.

Top module: `fbus_tx_guard`

## Requirements
- R1: After reset `drv_lo`=0, `drv_hi`=0, `idle_adj`=1 and `jabber_active`=0.
- R2: When `tx_en` is sampled 0, the next outputs are the static pattern (`drv_lo`=0, `drv_hi`=0, `idle_adj`=1), whatever `tx_dat` is.
- R3: When `tx_en`=1, `tx_dat`=1 and no fault is present, the next outputs are the high pattern (`drv_lo`=1, `drv_hi`=1, `idle_adj`=0).
- R4: When `tx_en`=1, `tx_dat`=0 and no fault is present, the next outputs are the low pattern (`drv_lo`=1, `drv_hi`=0, `idle_adj`=0).
- R5: Each output reflects the inputs sampled at the previous rising clock edge. A toggling `tx_dat` appears on `drv_hi` exactly one cycle later.
- R6: `idle_adj` is never 1 while `drv_lo` or `drv_hi` is 1, and `drv_hi` is never 1 without `drv_lo`.
- R7: With `tx_en` high on JAB_LIMIT consecutive rising edges, the outputs keep driving. On edge JAB_LIMIT+1 they fall to the static pattern and `jabber_active` becomes 1.
- R8: While `tx_en` stays high after a fault, `jabber_active` stays 1 and the outputs stay static for any `tx_dat`.
- R9: The first edge that samples `tx_en`=0 clears `jabber_active`. A later assertion of `tx_en` drives normally again.
- R10: A single cycle with `tx_en` low restarts the count, so two runs of JAB_LIMIT cycles separated by one low cycle raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable from the controller |
| tx_dat | input | 1 | Transmit data, 1 = high level, 0 = low level |
| drv_lo | output | 1 | Lower drive switch, closed for both low and high levels |
| drv_hi | output | 1 | Upper drive switch, closed for the high level only |
| idle_adj | output | 1 | Idle-level adjust switch, closed only at the static level |
| jabber_active | output | 1 | Fault latch: transmission cut off for over-long enable |

## Verification
The hardest condition to reach is the exact edge of the timeout. The bench must tell apart the last cycle that may still drive from the first cycle that must not. It must also tell a genuine timeout from two long bursts that are separated by only one idle cycle.

The bench shrinks the limit to a few dozen cycles through the parameter. It holds enable for exactly that many edges and checks the drive on every edge. It then adds one edge and expects the cut-off. A separate scenario drops enable for a single cycle between two full-length bursts, to show that the count restarts.

// File: rtl/fbus_tx_guard.sv
module fbus_tx_guard #(
  parameter int JAB_LIMIT = 250000,
  localparam int CNT_W = $clog2(JAB_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_dat,
  output logic drv_lo,
  output logic drv_hi,
  output logic idle_adj,
  output logic jabber_active
);

  logic [CNT_W-1:0] run_cnt;
  logic             jab_q;
  logic             jab_nxt;
  logic             drive_ok;

  assign jab_nxt  = tx_en & (jab_q | (run_cnt == CNT_W'(JAB_LIMIT)));
  assign drive_ok = tx_en & ~jab_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      jab_q   <= 1'b0;
    end else begin
      jab_q <= jab_nxt;
      if (!tx_en)
        run_cnt <= '0;
      else if (run_cnt != CNT_W'(JAB_LIMIT))
        run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_lo   <= 1'b0;
      drv_hi   <= 1'b0;
      idle_adj <= 1'b1;
    end else begin
      drv_lo   <= drive_ok;
      drv_hi   <= drive_ok & tx_dat;
      idle_adj <= ~drive_ok;
    end
  end

  assign jabber_active = jab_q;

endmodule

// File: rtl/fbus_tx_guard_chk.sv
module fbus_tx_guard_chk #(
  parameter int JAB_LIMIT = 250000,
  localparam int RW = $clog2(JAB_LIMIT + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_dat,
  input logic drv_lo,
  input logic drv_hi,
  input logic idle_adj,
  input logic jabber_active
);

  logic [RW-1:0] hi_run;
  logic          seen_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      seen_edge <= 1'b0;
    end else begin
      seen_edge <= 1'b1;
      if (!tx_en)
        hi_run <= '0;
      else if (hi_run <= RW'(JAB_LIMIT))
        hi_run <= hi_run + 1'b1;
    end
  end

  // R6
  no_switch_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_adj && (drv_lo || drv_hi)) && (drv_hi -> drv_lo));

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (idle_adj && !drv_lo && !drv_hi && !jabber_active));

  // R8
  fault_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jabber_active && tx_en) |=> (jabber_active && idle_adj));

  // R7
  timeout_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jabber_active == (hi_run > RW'(JAB_LIMIT)));

  // R5
  data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && tx_en && hi_run < RW'(JAB_LIMIT)) |=> (drv_hi == $past(tx_dat)));

endmodule

bind fbus_tx_guard fbus_tx_guard_chk #(.JAB_LIMIT(JAB_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_dat(tx_dat),
  .drv_lo(drv_lo), .drv_hi(drv_hi), .idle_adj(idle_adj),
  .jabber_active(jabber_active)
);

// File: tb/sim_fbus_tx_guard.sv
`timescale 1ns/1ps
module sim_fbus_tx_guard;
  localparam int LIM = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic tx_dat = 1'b0;
  logic drv_lo, drv_hi, idle_adj, jabber_active;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fbus_tx_guard #(.JAB_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_dat(tx_dat),
    .drv_lo(drv_lo), .drv_hi(drv_hi), .idle_adj(idle_adj),
    .jabber_active(jabber_active)
  );

  task automatic chk(input string tag, input logic [2:0] exp_sw, input logic exp_jab);
    logic [3:0] act, exp;
    act = {drv_lo, drv_hi, idle_adj, jabber_active};
    exp = {exp_sw, exp_jab};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lo/hi/adj/jab actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  localparam logic [2:0] ST = 3'b001, LO = 3'b100, HI = 3'b110;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_en = 1'b0; tx_dat = 1'b1;
    repeat (3) step();
    chk("R1 reset", ST, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", ST, 1'b0);
  endtask

  task automatic t_idle();
    tx_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tx_dat = i[0];
      step();
      chk("R2 enable low", ST, 1'b0);
    end
  endtask

  task automatic t_levels();
    logic [7:0] pat;
    logic prev;
    pat = 8'b1011_0010;
    tx_en = 1'b0; step();
    tx_en = 1'b1; tx_dat = 1'b1; step();
    chk("R3 high level", HI, 1'b0);
    tx_dat = 1'b0; step();
    chk("R4 low level", LO, 1'b0);
    prev = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tx_dat = pat[i];
      checks++;
      if (drv_hi !== prev) begin
        errors++;
        $display("FAIL R5 before edge drv_hi actual=%b expected=%b", drv_hi, prev);
      end
      step();
      chk("R5 follow data", pat[i] ? HI : LO, 1'b0);
      prev = pat[i];
    end
    tx_en = 1'b0; step();
    chk("R2 back to idle", ST, 1'b0);
  endtask

  task automatic t_jabber();
    tx_en = 1'b0; step();
    tx_en = 1'b1; tx_dat = 1'b1;
    for (int i = 1; i <= LIM; i++) begin
      tx_dat = ~tx_dat;
      step();
      chk("R7 still driving", tx_dat ? HI : LO, 1'b0);
    end
    step();
    chk("R7 cut off at limit", ST, 1'b1);
    for (int i = 0; i < 5; i++) begin
      tx_dat = i[0];
      step();
      chk("R8 fault held", ST, 1'b1);
    end
  endtask

  task automatic t_release();
    tx_en = 1'b0; tx_dat = 1'b1; step();
    chk("R9 fault cleared", ST, 1'b0);
    tx_en = 1'b1; step();
    chk("R9 drives again", HI, 1'b0);
    tx_en = 1'b0; step();
  endtask

  task automatic t_restart();
    tx_en = 1'b1; tx_dat = 1'b0;
    repeat (LIM) step();
    chk("R10 first burst end", LO, 1'b0);
    tx_en = 1'b0; step();
    chk("R10 gap", ST, 1'b0);
    tx_en = 1'b1;
    repeat (LIM) step();
    chk("R10 second burst end", LO, 1'b0);
    step();
    chk("R10 second burst timeout", ST, 1'b1);
    tx_en = 1'b0; step();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_levels();
    t_jabber();
    t_release();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule